// File: doc/BRIEF.md
# Channel Context Save and Restore Sequencer

This block sits between a four-channel cipher, hash and copy engine and system memory. Each channel has a private slot in a context area in memory. After a control packet finishes on a channel, the block copies the state that the packet used (the 128-bit chaining state of a block cipher, the 288-bit running state of a digest, or both) from the engine's capture ports into that channel's slot. Before a channel is started again, it reads the slot back and hands each word to the engine's state-register load port. The engine waits for the `done` pulse before it begins the packet.

Software supplies the base address of the area. The slots are laid out in reverse channel order, so channel 3 is lowest in memory. A system that only uses the high channels for cipher or digest work can therefore size the area to cover only those channels. A switch-off input disables all saving and reloading. A reload is also skipped when the requested channel's state is still held in the engine.

Top module: `ctx_swap`

## Requirements
- R1: Channel c owns a 52-byte slot that starts at base + (3 - c) * 0x34. Channel 3 is at offset 0x00 and channel 0 is at offset 0x9C.
- R2: Within a slot, the cipher part is 4 words at slot offsets 0x00, 0x04, 0x08 and 0x0C. The hash part is 9 words at offsets 0x10 through 0x30. Words are moved at increasing addresses, and the cipher part is moved before the hash part.
- R3: A save request (`save_go` pulse) writes the cipher words only when `save_cbc` is 1 and the hash words only when `save_sha` is 1. Cipher word i is `cipher_cap[32i+31:32i]` and hash word j is `hash_cap[32j+31:32j]`. A save with both flags at 0 writes nothing.
- R4: A load request (`load_go` pulse) reads the cipher part only when `load_cbc` is 1 and the hash part only when `load_sha` is 1. Each read word is presented on the load port in the cycle its acknowledge is high, as follows: `st_ld_en` = 1, `st_ld_hash` = 0 for cipher or 1 for hash, `st_ld_idx` = the word index, and `st_ld_data` = the read data.
- R5: While `switch_off` is 1, accepted save and load requests cause no memory access and no load strobe. They only produce a `done` pulse.
- R6: The resident channel is the channel of the last accepted save or load made with `switch_off` at 0. There is no resident channel after reset. A load request for the resident channel performs no reads.
- R7: Only one memory request is outstanding at a time. `mem_req` stays high with a stable address and direction until `mem_ack` is seen.
- R8: `busy` rises in the cycle after a request that needs memory traffic and stays high through the cycle of the last acknowledge. `done` is a one-cycle pulse. It comes in the cycle after the last acknowledge, or in the cycle after the request when there is no traffic. `busy` is never high together with `done`. After reset, `busy`, `done` and `mem_req` are 0.
- R9: `ctx_base` is sampled when a request is accepted, and its two low bits are treated as 0.
- R10: Requests that arrive while `busy` is high are ignored. When `save_go` and `load_go` arrive in the same cycle, only the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_base | input | 32 | Byte base address of the context area |
| switch_off | input | 1 | Disables saving and reloading |
| save_go | input | 1 | Packet completed: save request pulse |
| save_chan | input | 2 | Channel to save |
| save_cbc | input | 1 | Packet used chained block cipher mode |
| save_sha | input | 1 | Packet used a digest function |
| load_go | input | 1 | Channel activation: load request pulse |
| load_chan | input | 2 | Channel to load |
| load_cbc | input | 1 | Next packet needs the cipher state |
| load_sha | input | 1 | Next packet needs the hash state |
| cipher_cap | input | 128 | Cipher state from the engine |
| hash_cap | input | 288 | Hash state from the engine |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Request finished pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| st_ld_en | output | 1 | State-register load strobe |
| st_ld_hash | output | 1 | 0 = cipher word, 1 = hash word |
| st_ld_idx | output | 4 | Word index within the state |
| st_ld_data | output | 32 | Word to load |

## Verification
Saves are tried with each combination of the two mode flags, on different channels and with a misaligned base. Each combination separates a correct part selection from one that writes an unused part or skips a needed one. Loads then read back those slots, which shows whether the slot placement, the word order and the index of each delivered word all match what was written. Channel reuse, the switch-off input, a request during a transfer and a save and load arriving in the same cycle show apart the skip conditions, the ignore rule and the priority. A reference model in the bench predicts every memory access, `busy`, `done` and every load strobe cycle by cycle. The memory acknowledge is given with a varying delay, which tests that requests are held until acknowledged.

// File: rtl/ctx_swap_pkg.sv
package ctx_swap_pkg;
    localparam int AW         = 32;
    localparam int DW         = 32;
    localparam int NUM_CH     = 4;
    localparam int CIPH_WORDS = 4;
    localparam int HASH_WORDS = 9;
    localparam int CH_W       = $clog2(NUM_CH);
    localparam int CI_W       = $clog2(CIPH_WORDS);
    localparam int IDX_W      = $clog2((HASH_WORDS > CIPH_WORDS) ? HASH_WORDS : CIPH_WORDS);

    typedef enum logic {ST_IDLE, ST_XFER} xfer_st_e;

    typedef struct packed {
        xfer_st_e         st;
        logic             we;
        logic [CH_W-1:0]  chan;
        logic             part;     // 0 = cipher words, 1 = hash words
        logic             do_hash;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]    base;
        logic             done;
        logic             res_v;
        logic [CH_W-1:0]  res_ch;
    } ctx_reg_t;
endpackage

// File: rtl/ctx_swap_addr.sv
module ctx_swap_addr #(
    parameter int AW         = 32,
    parameter int NUM_CH     = 4,
    parameter int CIPH_WORDS = 4,
    parameter int HASH_WORDS = 9,
    parameter int CH_W       = 2,
    parameter int IDX_W      = 4
) (
    input  logic [AW-1:0]    base,
    input  logic [CH_W-1:0]  chan,
    input  logic             part,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    localparam int SLOT_BYTES = (CIPH_WORDS + HASH_WORDS) * 4;
    localparam int HASH_OFS   = CIPH_WORDS * 4;

    // Highest channel takes the lowest slot.
    logic [CH_W-1:0] rank;
    assign rank = CH_W'(NUM_CH - 1) - chan;

    assign addr = base
                + AW'(rank) * AW'(SLOT_BYTES)
                + (part ? AW'(HASH_OFS) : AW'(0))
                + AW'({idx, 2'b00});
endmodule

// File: rtl/ctx_swap.sv
module ctx_swap
    import ctx_swap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ctx_base,
    input  logic              switch_off,
    input  logic              save_go,
    input  logic [CH_W-1:0]   save_chan,
    input  logic              save_cbc,
    input  logic              save_sha,
    input  logic              load_go,
    input  logic [CH_W-1:0]   load_chan,
    input  logic              load_cbc,
    input  logic              load_sha,
    input  logic [CIPH_WORDS*DW-1:0] cipher_cap,
    input  logic [HASH_WORDS*DW-1:0] hash_cap,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              st_ld_en,
    output logic              st_ld_hash,
    output logic [IDX_W-1:0]  st_ld_idx,
    output logic [DW-1:0]     st_ld_data
);
    localparam int HW_SLOTS = 1 << IDX_W;

    ctx_reg_t q, d;

    // Word views of the captured engine state.
    logic [DW-1:0] cw [CIPH_WORDS];
    logic [DW-1:0] hw [HW_SLOTS];

    generate
        for (genvar g = 0; g < CIPH_WORDS; g++) begin : g_cw
            assign cw[g] = cipher_cap[g*DW +: DW];
        end
        for (genvar g = 0; g < HW_SLOTS; g++) begin : g_hw
            if (g < HASH_WORDS) begin : g_on
                assign hw[g] = hash_cap[g*DW +: DW];
            end else begin : g_off
                assign hw[g] = '0;
            end
        end
    endgenerate

    logic unused_base_lsb;
    assign unused_base_lsb = &{1'b0, ctx_base[1:0]};

    logic             xfer;
    logic [IDX_W-1:0] last_idx;
    assign xfer     = (q.st == ST_XFER);
    assign last_idx = q.part ? IDX_W'(HASH_WORDS - 1) : IDX_W'(CIPH_WORDS - 1);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (save_go) begin
                    if (!switch_off) begin
                        d.res_v  = 1'b1;
                        d.res_ch = save_chan;
                    end
                    if (switch_off || !(save_cbc || save_sha)) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = ST_XFER;
                        d.we      = 1'b1;
                        d.chan    = save_chan;
                        d.part    = !save_cbc;
                        d.do_hash = save_sha;
                        d.idx     = '0;
                        d.base    = {ctx_base[AW-1:2], 2'b00};
                    end
                end else if (load_go) begin
                    if (!switch_off) begin
                        d.res_v  = 1'b1;
                        d.res_ch = load_chan;
                    end
                    if (switch_off || (q.res_v && q.res_ch == load_chan)
                        || !(load_cbc || load_sha)) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = ST_XFER;
                        d.we      = 1'b0;
                        d.chan    = load_chan;
                        d.part    = !load_cbc;
                        d.do_hash = load_sha;
                        d.idx     = '0;
                        d.base    = {ctx_base[AW-1:2], 2'b00};
                    end
                end
            end
            ST_XFER: begin
                if (mem_ack) begin
                    if (q.idx == last_idx) begin
                        if (!q.part && q.do_hash) begin
                            d.part = 1'b1;
                            d.idx  = '0;
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    ctx_swap_addr #(
        .AW(AW), .NUM_CH(NUM_CH), .CIPH_WORDS(CIPH_WORDS),
        .HASH_WORDS(HASH_WORDS), .CH_W(CH_W), .IDX_W(IDX_W)
    ) u_addr (
        .base (q.base),
        .chan (q.chan),
        .part (q.part),
        .idx  (q.idx),
        .addr (mem_addr)
    );

    assign busy       = xfer;
    assign done       = q.done;
    assign mem_req    = xfer;
    assign mem_we     = q.we;
    assign mem_wdata  = q.part ? hw[q.idx] : cw[q.idx[CI_W-1:0]];
    assign st_ld_en   = xfer && !q.we && mem_ack;
    assign st_ld_hash = q.part;
    assign st_ld_idx  = q.idx;
    assign st_ld_data = mem_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req || mem_addr == $past(mem_addr) + 32'd4); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !mem_req); // R8
    AST_LD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        st_ld_en |-> mem_req && mem_ack && !mem_we); // R4
    AST_SWITCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(switch_off)); // R5
    AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R9
endmodule

// File: tb/ctx_swap_test.sv
module ctx_swap_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  ctx_base = 32'h0;
    logic         switch_off = 1'b0;
    logic         save_go = 1'b0, save_cbc = 1'b0, save_sha = 1'b0;
    logic [1:0]   save_chan = 2'd0;
    logic         load_go = 1'b0, load_cbc = 1'b0, load_sha = 1'b0;
    logic [1:0]   load_chan = 2'd0;
    logic [127:0] cipher_cap = '0;
    logic [287:0] hash_cap = '0;
    logic         busy, done, mem_req, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_ack = 1'b0;
    logic [31:0]  mem_rdata = '0;
    logic         st_ld_en, st_ld_hash;
    logic [3:0]   st_ld_idx;
    logic [31:0]  st_ld_data;

    always #5 clk = ~clk;

    ctx_swap uut (.*);

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        bit          hsel;
        int          idx;
    } xact_t;

    xact_t       q_exp[$];
    logic [31:0] ref_mem [logic [31:0]];
    logic [31:0] dmem    [logic [31:0]];
    bit          m_busy, m_done, m_rv;
    int          m_rch;
    int          errs = 0, checks = 0, xfers = 0, lag = 0;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void push_part(bit we, int ch, bit hsel, logic [31:0] base);
        int n = hsel ? 9 : 4;
        for (int i = 0; i < n; i++) begin
            xact_t t;
            t.we   = we;
            t.addr = {base[31:2], 2'b00} + (3 - ch) * 52 + (hsel ? 16 : 0) + 4 * i;
            t.hsel = hsel;
            t.idx  = i;
            if (we) begin
                t.data = hsel ? hash_cap[i*32 +: 32] : cipher_cap[i*32 +: 32];
                ref_mem[t.addr] = t.data;
            end else begin
                t.data = ref_mem.exists(t.addr) ? ref_mem[t.addr] : 32'h0;
            end
            q_exp.push_back(t);
        end
    endfunction

    // Behavioural reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rv = 0; m_rch = 0;
            q_exp.delete();
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (mem_ack) begin
                    void'(q_exp.pop_front());
                    if (q_exp.size() == 0) begin m_busy = 0; m_done = 1; end
                end
            end else if (save_go) begin
                if (!switch_off) begin
                    m_rv = 1; m_rch = save_chan;
                    if (save_cbc) push_part(1, save_chan, 0, ctx_base);
                    if (save_sha) push_part(1, save_chan, 1, ctx_base);
                end
                if (q_exp.size() == 0) m_done = 1; else m_busy = 1;
            end else if (load_go) begin
                if (!switch_off) begin
                    if (!(m_rv && m_rch == load_chan)) begin
                        if (load_cbc) push_part(0, load_chan, 0, ctx_base);
                        if (load_sha) push_part(0, load_chan, 1, ctx_base);
                    end
                    m_rv = 1; m_rch = load_chan;
                end
                if (q_exp.size() == 0) m_done = 1; else m_busy = 1;
            end
        end
    end

    // Memory responder.
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            xfers++;
            if (mem_we) dmem[mem_addr] = mem_wdata;
        end
    end

    // Per-cycle comparison, then acknowledge for the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == m_busy, "R8 busy", busy, m_busy);
            chk(done == m_done, "R8 done", done, m_done);
            chk(mem_req == m_busy, "R7 mem_req", mem_req, m_busy);
            if (mem_req && q_exp.size() > 0) begin
                chk(mem_addr == q_exp[0].addr, "R1 R2 address", mem_addr, q_exp[0].addr);
                chk(mem_we == q_exp[0].we, "R3 R4 direction", mem_we, q_exp[0].we);
                if (q_exp[0].we)
                    chk(mem_wdata == q_exp[0].data, "R3 write data", mem_wdata, q_exp[0].data);
            end
            lag = (lag + 1) % 3;
            mem_ack = mem_req && (lag != 1);
            mem_rdata = (mem_req && dmem.exists(mem_addr)) ? dmem[mem_addr] : 32'h0;
            #1;
            chk(st_ld_en == (mem_ack && mem_req && !mem_we), "R4 load strobe",
                st_ld_en, mem_ack && mem_req && !mem_we);
            if (st_ld_en && q_exp.size() > 0) begin
                chk(st_ld_hash == q_exp[0].hsel, "R4 load part", st_ld_hash, q_exp[0].hsel);
                chk(st_ld_idx == q_exp[0].idx[3:0], "R4 load index", st_ld_idx, q_exp[0].idx);
                chk(st_ld_data == q_exp[0].data, "R4 load data", st_ld_data, q_exp[0].data);
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic fill_cap(int seed);
        for (int i = 0; i < 4; i++) cipher_cap[i*32 +: 32] = 32'hC1000000 + seed * 256 + i;
        for (int i = 0; i < 9; i++) hash_cap[i*32 +: 32] = 32'hA5000000 + seed * 256 + 16 + i;
    endtask

    task automatic settle();
        @(negedge clk);
        while (busy || m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic req(bit is_save, int ch, bit cbc, bit sha, logic [31:0] base,
                       int exp_n, string tag);
        int start;
        @(negedge clk);
        start = xfers;
        ctx_base = base;
        if (is_save) begin
            save_go = 1; save_chan = 2'(ch); save_cbc = cbc; save_sha = sha;
        end else begin
            load_go = 1; load_chan = 2'(ch); load_cbc = cbc; load_sha = sha;
        end
        @(negedge clk);
        save_go = 0; load_go = 0;
        ctx_base = 32'hDEAD0000;
        settle();
        chk(xfers - start == exp_n, tag, xfers - start, exp_n);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL R8 watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int start;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && mem_req == 0, "R8 reset state",
            {busy, done, mem_req}, 0);

        fill_cap(1); req(1, 3, 1, 1, 32'h1000, 13, "R1 R2 save ch3 both parts");
        fill_cap(2); req(1, 0, 0, 1, 32'h2003, 9,  "R9 R3 save ch0 hash only");
        fill_cap(3); req(1, 1, 1, 0, 32'h1000, 4,  "R3 save ch1 cipher only");
        fill_cap(4); req(1, 2, 0, 0, 32'h1000, 0,  "R3 save ch2 no mode");
        req(0, 2, 1, 0, 32'h1000, 0,  "R6 load resident ch2");
        req(0, 3, 1, 1, 32'h1000, 13, "R4 load ch3 both parts");
        req(0, 3, 1, 0, 32'h1000, 0,  "R6 load ch3 again");
        switch_off = 1;
        fill_cap(5); req(1, 1, 1, 0, 32'h1000, 0, "R5 save with switch off");
        req(0, 0, 0, 1, 32'h2000, 0, "R5 load with switch off");
        switch_off = 0;
        req(0, 0, 0, 1, 32'h2000, 9,  "R4 R9 load ch0 hash");
        req(0, 1, 1, 0, 32'h1000, 4,  "R4 load ch1 cipher");

        // R10: a load request during a save is ignored.
        fill_cap(6);
        @(negedge clk);
        start = xfers;
        ctx_base = 32'h1000; save_go = 1; save_chan = 2'd3; save_cbc = 1; save_sha = 1;
        @(negedge clk);
        save_go = 0;
        repeat (2) @(negedge clk);
        load_go = 1; load_chan = 2'd2; load_cbc = 1; load_sha = 1;
        @(negedge clk);
        load_go = 0;
        settle();
        chk(xfers - start == 13, "R10 request while busy", xfers - start, 13);

        // R10: save wins over a simultaneous load.
        fill_cap(7);
        @(negedge clk);
        start = xfers;
        ctx_base = 32'h1000;
        save_go = 1; save_chan = 2'd2; save_cbc = 1; save_sha = 0;
        load_go = 1; load_chan = 2'd0; load_cbc = 0; load_sha = 1;
        @(negedge clk);
        save_go = 0; load_go = 0;
        settle();
        chk(xfers - start == 4, "R10 save priority", xfers - start, 4);

        req(0, 3, 0, 0, 32'h1000, 0, "R4 load ch3 no mode");
        req(0, 3, 1, 1, 32'h1000, 0, "R6 resident after empty load");
        req(0, 2, 1, 0, 32'h1000, 4, "R4 load ch2 cipher");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule